// File: doc/BRIEF.md
# Timer clock select prescaler

This unit decides, cycle by cycle, whether a timer counter may advance. A 3-bit select code chooses the source: nothing at all, every system clock, a divided rate taken from a free-running binary prescaler (1/8, 1/64, 1/256 or 1/1024), or edges seen on an external pin (falling or rising). The result is a count-enable pulse one system clock wide that the timer samples on the same clock.

The external pin passes through a two-stage synchroniser before an edge detector. The pin is counted whatever its direction setting elsewhere on the chip, so software that drives the pin can step the timer itself. A prescaler-clear input restarts the divider, so a divided pulse comes exactly one full period after the clear.

The control is a small state machine whose states are the source modes: IDLE (stopped), FULL (every clock), TAP0 to TAP3 (divide by 8, 64, 256 and 1024), FALL and RISE (external edges). There is one kind of transition: on every clock the machine moves to the state that the sampled select code names, and from IDLE to IDLE while in reset. A second process drives the enable from the current state.

Top module: `tmr_clksel`

## Requirements
- R1: Select code 3'b000 (IDLE) yields no enable pulses.
- R2: Select code 3'b001 (FULL) holds the enable high on every system clock.
- R3: Select codes 3'b010, 3'b011, 3'b100 and 3'b101 yield exactly one enable per 8, 64, 256 and 1024 system clocks.
- R4: Select code 3'b110 (FALL) yields one enable for each high-to-low change of the external pin. A change sampled at clock edge a drives the enable high after edge a+2, for one cycle. Rising changes yield nothing.
- R5: Select code 3'b111 (RISE) yields one enable for each low-to-high change of the external pin, with the same timing as R4.
- R6: In codes 3'b000 to 3'b101 the external pin has no effect on the enable.
- R7: A prescaler clear sampled at edge e clears the divider. In a divided mode the first enable after it comes after edge e+N+1 (N the division ratio), and none comes while the clear is held.
- R8: Outside FULL, while the select code is unchanged, the enable is never high on two consecutive cycles.
- R9: A new select code sampled at edge k takes effect for the enable driven at edge k+1.
- R10: Reset (synchronous, active high) holds the enable low, clears the divider and enters IDLE. With code 3'b010, the first enable comes 9 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Source select code |
| ext_pin | input | 1 | External count pin, asynchronous |
| pre_clr | input | 1 | Prescaler clear, active high |
| cnt_en | output | 1 | Single-cycle count enable |

## Verification
Assertions check on every cycle that IDLE stays quiet and FULL stays high. They also check that an enable never repeats in the next cycle while the mode is steady, that a clear silences divided modes for the following cycle, and that each synchronised pin edge in FALL or RISE produces an enable three cycles later. The exact division ratios can only be shown by the bench's scenarios. So can the indifference to the pin in non-external modes, the full-period delay after a clear or reset, and the one-cycle reaction to a select change. The bench counts pulses over fixed windows and times first pulses.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 4;

    // Select codes seen at the port.
    typedef enum logic [SEL_W-1:0] {
        SEL_OFF      = 3'd0,
        SEL_FULL     = 3'd1,
        SEL_D8       = 3'd2,
        SEL_D64      = 3'd3,
        SEL_D256     = 3'd4,
        SEL_D1024    = 3'd5,
        SEL_EXT_FALL = 3'd6,
        SEL_EXT_RISE = 3'd7
    } sel_code_e;

    // Source states of the control machine.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FULL = 3'd1,
        ST_TAP0 = 3'd2,
        ST_TAP1 = 3'd3,
        ST_TAP2 = 3'd4,
        ST_TAP3 = 3'd5,
        ST_FALL = 3'd6,
        ST_RISE = 3'd7
    } src_state_e;

    // log2 of each divider tap's ratio.
    function automatic int tap_log(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
    parameter int NUM_TAPS = tcs_pkg::NUM_TAPS,
    parameter int PRE_W    = tcs_pkg::tap_log(NUM_TAPS - 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    output logic [NUM_TAPS-1:0] tap_o
);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Each tap fires for one cycle as its low-order field wraps.
    for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
        localparam int LG = tcs_pkg::tap_log(gi);
        logic tick_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                tick_q <= 1'b0;
            end else begin
                tick_q <= &cnt_q[LG-1:0];
            end
        end
        assign tap_o[gi] = tick_q;
    end

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SH_W-2:0], pin_i};
        end
    end

    assign rise_o =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign fall_o = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];

endmodule

// File: rtl/tcs_mode_fsm.sv
module tcs_mode_fsm
    import tcs_pkg::*;
#(
    parameter int NUM_TAPS = tcs_pkg::NUM_TAPS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [NUM_TAPS-1:0] tap_i,
    input  logic                ext_rise_i,
    input  logic                ext_fall_i,
    output logic                en_o
);

    src_state_e state_q;
    src_state_e state_d;
    logic       en_q;

    // Next state: the mode named by the select code.
    always_comb begin
        state_d = ST_IDLE;
        unique case (sel_i)
            SEL_OFF:      state_d = ST_IDLE;
            SEL_FULL:     state_d = ST_FULL;
            SEL_D8:       state_d = ST_TAP0;
            SEL_D64:      state_d = ST_TAP1;
            SEL_D256:     state_d = ST_TAP2;
            SEL_D1024:    state_d = ST_TAP3;
            SEL_EXT_FALL: state_d = ST_FALL;
            SEL_EXT_RISE: state_d = ST_RISE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: en_q <= 1'b0;
                ST_FULL: en_q <= 1'b1;
                ST_TAP0: en_q <= tap_i[0];
                ST_TAP1: en_q <= tap_i[1];
                ST_TAP2: en_q <= tap_i[2];
                ST_TAP3: en_q <= tap_i[3];
                ST_FALL: en_q <= ext_fall_i;
                ST_RISE: en_q <= ext_rise_i;
                default: en_q <= 1'b0;
            endcase
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/tmr_clksel.sv
module tmr_clksel
    import tcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             ext_pin,
    input  logic             pre_clr,
    output logic             cnt_en
);

    logic [NUM_TAPS-1:0] taps;
    logic                pin_rise;
    logic                pin_fall;

    tcs_prescaler #(
        .NUM_TAPS (NUM_TAPS)
    ) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (pre_clr),
        .tap_o (taps)
    );

    tcs_pin_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_pin),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    tcs_mode_fsm #(
        .NUM_TAPS (NUM_TAPS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sel_i      (clk_sel),
        .tap_i      (taps),
        .ext_rise_i (pin_rise),
        .ext_fall_i (pin_fall),
        .en_o       (cnt_en)
    );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
    import tcs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] clk_sel,
    input logic       ext_pin,
    input logic       pre_clr,
    input logic       cnt_en,
    input logic [2:0] mode
);

    logic in_div;
    assign in_div = (mode == ST_TAP0) || (mode == ST_TAP1) ||
                    (mode == ST_TAP2) || (mode == ST_TAP3);

    // R1
    p_stop_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(clk_sel) == 3'b000) |=> !cnt_en);

    // R2
    p_full_rate_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(clk_sel) == 3'b001) |=> cnt_en);

    // R4
    p_fall_lat_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4) &&
         $past(mode) == ST_FALL && !$past(ext_pin, 3) && $past(ext_pin, 4))
        |-> cnt_en);

    // R5
    p_rise_lat_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4) &&
         $past(mode) == ST_RISE && $past(ext_pin, 3) && !$past(ext_pin, 4))
        |-> cnt_en);

    // R7
    p_clr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (pre_clr ##1 in_div) |=> !cnt_en);

    // R8
    p_single_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && mode != ST_FULL && $stable(mode)) |=> !cnt_en);

endmodule

bind tmr_clksel tcs_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_sel (clk_sel),
    .ext_pin (ext_pin),
    .pre_clr (pre_clr),
    .cnt_en  (cnt_en),
    .mode    (u_fsm.state_q)
);

// File: tb/tmr_clksel_bench.sv
module tmr_clksel_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] clk_sel = 3'b000;
    logic       ext_pin = 1'b0;
    logic       pre_clr = 1'b0;
    logic       cnt_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmr_clksel u_tmr_clksel (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (clk_sel),
        .ext_pin (ext_pin),
        .pre_clr (pre_clr),
        .cnt_en  (cnt_en)
    );

    // Vector table: select code and expected pulses in a 2048-cycle window
    // while the pin carries five full pulses.
    localparam int WIN = 2048;
    localparam logic [2:0] VSEL [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam int         VEXP [8] = '{0, 2048, 256, 32, 8, 2, 5, 5};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'd0:    return "R1/R6";
            3'd1:    return "R2/R6";
            3'd6:    return "R4";
            3'd7:    return "R5";
            default: return "R3/R6";
        endcase
    endfunction

    task automatic pin_pulses();
        repeat (5) begin
            ext_pin = 1'b1;
            repeat (4) @(negedge clk);
            ext_pin = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic count_win(output int c);
        c = 0;
        repeat (WIN) begin
            @(negedge clk);
            if (cnt_en) c++;
        end
    endtask

    // Index (1-based, in negedges) of the first enable within lim cycles.
    task automatic first_pulse(input int lim, output int idx);
        idx = 0;
        for (int j = 1; j <= lim; j++) begin
            @(negedge clk);
            if (cnt_en && idx == 0) idx = j;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        int cnt;
        int idx;
        int dbl;
        logic prev;

        // R10: enable low during reset
        repeat (4) @(negedge clk);
        check("R10 reset low", int'(cnt_en), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // Vector walk (R1, R2, R3, R4, R5, R6)
        for (int v = 0; v < 8; v++) begin
            clk_sel = VSEL[v];
            ext_pin = 1'b0;
            repeat (12) @(negedge clk);
            fork
                count_win(cnt);
                pin_pulses();
            join
            check(req_of(VSEL[v]), cnt, VEXP[v]);
        end

        // R9: select change takes effect one edge later
        clk_sel = 3'd0;
        repeat (4) @(negedge clk);
        clk_sel = 3'd1;
        @(negedge clk);
        check("R9 before", int'(cnt_en), 0);
        @(negedge clk);
        check("R9 after", int'(cnt_en), 1);

        // R7: clear restarts divide-by-8
        clk_sel = 3'd2;
        repeat (20) @(negedge clk);
        pre_clr = 1'b1;
        @(negedge clk);
        pre_clr = 1'b0;
        first_pulse(9, idx);
        check("R7 div8 first", idx, 9);

        // R7: held clear gives no pulses
        pre_clr = 1'b1;
        repeat (2) @(negedge clk);
        cnt = 0;
        repeat (40) begin
            @(negedge clk);
            if (cnt_en) cnt++;
        end
        pre_clr = 1'b0;
        check("R7 held", cnt, 0);

        // R7: clear with divide-by-1024
        clk_sel = 3'd5;
        repeat (4) @(negedge clk);
        pre_clr = 1'b1;
        @(negedge clk);
        pre_clr = 1'b0;
        first_pulse(1025, idx);
        check("R7 div1024 first", idx, 1025);

        // R8: no back-to-back pulses in divide-by-8
        clk_sel = 3'd2;
        repeat (4) @(negedge clk);
        dbl = 0;
        prev = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (cnt_en && prev) dbl++;
            prev = cnt_en;
        end
        check("R8 single", dbl, 0);

        // R4: falling edge latency and rising ignored
        clk_sel = 3'd6;
        ext_pin = 1'b1;
        repeat (8) @(negedge clk);
        ext_pin = 1'b0;
        @(negedge clk);
        check("R4 n1", int'(cnt_en), 0);
        @(negedge clk);
        check("R4 n2", int'(cnt_en), 0);
        @(negedge clk);
        check("R4 n3", int'(cnt_en), 1);
        @(negedge clk);
        check("R4 n4", int'(cnt_en), 0);
        repeat (4) @(negedge clk);
        ext_pin = 1'b1;
        cnt = 0;
        repeat (8) begin
            @(negedge clk);
            if (cnt_en) cnt++;
        end
        check("R4 rise ignored", cnt, 0);

        // R5: rising edge latency
        clk_sel = 3'd7;
        ext_pin = 1'b0;
        repeat (8) @(negedge clk);
        ext_pin = 1'b1;
        first_pulse(6, idx);
        check("R5 latency", idx, 3);

        // R10: reset mid-run, then first divide-by-8 pulse
        clk_sel = 3'd2;
        ext_pin = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 in reset", int'(cnt_en), 0);
        rst = 1'b0;
        first_pulse(9, idx);
        check("R10 after reset", idx, 9);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule